// File: doc/BRIEF.md
# Dual-Issue Pair Gate

This block sits between decode and the issue stage of an in-order machine that fetches two 32-bit instructions at a time as one aligned 64-bit group. In each cycle it looks at the decoded kind of both instructions, their three register numbers each, a valid bit per slot and a ready flag per slot from the back end. From these it decides whether none, the first, or both instructions leave in that cycle.

The first slot is for integer work: ALU operations, loads, stores and branches. The second slot may only send a floating-point operation. It goes only together with the first slot, and only if it does not depend on the first slot through the floating-point register file. The integer and floating-point register files are kept apart, so equal register numbers in different files never count as a conflict. When the second slot stays behind, the fetch stage is told to shift the group by one, so that the held instruction comes back as the first slot of the next group. Registered dispatch strobes pass the decision on to the execution units one cycle later.

The 4-bit decoded kind is encoded as follows. Bits [3:2] give the class: 00 integer ALU, 01 memory, 10 branch, 11 floating-point. For the memory class, bit [1] is 1 for a load and 0 for a store, and bit [0] is 1 when the data register is in the floating-point file. A floating-point operation reads `rs` and `rt` and writes `rd`, all three in the floating-point file. A floating-point load writes `rd` in the floating-point file. A floating-point store reads its data from `rt` in the floating-point file. No other kind touches the floating-point file.

Top module: `dual_issue_gate`

## Requirements
- R1: Slot 0 issues (`iss0_en`=1) exactly when `s0_valid` and `s0_ready` are both 1, whatever its class.
- R2: `iss1_en` is never 1 while `iss0_en` is 0, so the second instruction never leaves ahead of the first.
- R3: Slot 1 can issue only when its kind is in class 11 (floating-point) and the slot 0 kind is not in class 11. Any other class pairing is single-issue.
- R4: A read-after-write conflict blocks slot 1. This is the case when slot 0 is a floating-point load (kind 4'b0111) whose `s0_rd` equals `s1_rs` or `s1_rt`. An integer-file destination with the same number, such as an integer load (kind 4'b0110), does not block.
- R5: A write-after-write conflict blocks slot 1. This is the case when slot 0 is a floating-point load whose `s0_rd` equals `s1_rd`.
- R6: A write-after-read conflict blocks slot 1. This is the case when slot 0 is a floating-point store (kind 4'b0101) whose `s0_rt` equals `s1_rd`.
- R7: Slot 1 also needs `s1_valid` and `s1_ready`. When all conditions hold, both slots issue in the same cycle.
- R8: `stall` is 1 exactly when `s0_valid` is 1 and slot 0 does not issue. In that case neither slot issues.
- R9: `shift_one` is 1 exactly when slot 0 is consumed (issued or not valid), `s1_valid` is 1 and slot 1 does not issue.
- R10: `disp0_q` and `disp1_q` are 0 during reset. After reset, each equals its slot's issue enable from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s0_valid | input | 1 | Slot 0 holds an instruction |
| s0_kind | input | 4 | Slot 0 decoded kind |
| s0_rd | input | REG_W | Slot 0 destination register |
| s0_rs | input | REG_W | Slot 0 first source register |
| s0_rt | input | REG_W | Slot 0 second source register |
| s0_ready | input | 1 | Back end can accept slot 0 |
| s1_valid | input | 1 | Slot 1 holds an instruction |
| s1_kind | input | 4 | Slot 1 decoded kind |
| s1_rd | input | REG_W | Slot 1 destination register |
| s1_rs | input | REG_W | Slot 1 first source register |
| s1_rt | input | REG_W | Slot 1 second source register |
| s1_ready | input | 1 | Back end can accept slot 1 |
| iss0_en | output | 1 | Slot 0 issues this cycle |
| iss1_en | output | 1 | Slot 1 issues this cycle |
| stall | output | 1 | Slot 0 is valid but held |
| shift_one | output | 1 | Fetch shifts by one; slot 1 returns as slot 0 |
| disp0_q | output | 1 | Registered dispatch strobe for the integer side |
| disp1_q | output | 1 | Registered dispatch strobe for the floating-point side |

## Verification
The two decisions that can fall in the same cycle are the issue of slot 0 and the holding back of slot 1. A held slot 1 may come from a class mismatch, a register conflict or a missing ready, and in each case the bench must see `iss0_en` and `shift_one` high together. Random stimulus draws register numbers from a range of four, so that matches across the files happen often, and it mixes floating-point loads and stores with integer kinds. Directed pairs set a wrong class and a register match in the same pair, and also put a matching number in the integer file, which must not block. Every pair is judged against a bench model that rebuilds the three conflict kinds from the kind encoding, and the dispatch strobes are checked one cycle later.

// File: rtl/dig_pkg.sv
package dig_pkg;

  localparam int KIND_W = 4;

  typedef enum logic [1:0] {
    CLS_INT = 2'b00,
    CLS_MEM = 2'b01,
    CLS_BR  = 2'b10,
    CLS_FP  = 2'b11
  } op_class_e;

  function automatic op_class_e class_of(input logic [KIND_W-1:0] kind);
    return op_class_e'(kind[3:2]);
  endfunction

  // destination lands in the floating-point file
  function automatic logic writes_fp(input logic [KIND_W-1:0] kind);
    return (class_of(kind) == CLS_FP) ||
           (class_of(kind) == CLS_MEM && kind[1] && kind[0]);
  endfunction

  // memory store whose data register sits in the floating-point file
  function automatic logic stores_fp(input logic [KIND_W-1:0] kind);
    return (class_of(kind) == CLS_MEM) && !kind[1] && kind[0];
  endfunction

endpackage

// File: rtl/dig_slot_decode.sv
module dig_slot_decode
  import dig_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [KIND_W-1:0] kind,
  input  logic [REG_W-1:0]  rd,
  input  logic [REG_W-1:0]  rs,
  input  logic [REG_W-1:0]  rt,
  output op_class_e         cls,
  output logic              wr_fp,
  output logic [REG_W-1:0]  wr_idx,
  output logic [1:0]        rd_fp,
  output logic [REG_W-1:0]  rd_idx [2]
);

  always_comb begin
    cls       = class_of(kind);
    wr_fp     = writes_fp(kind);
    wr_idx    = rd;
    rd_idx[0] = rs;
    rd_idx[1] = rt;
    rd_fp[0]  = (cls == CLS_FP);
    rd_fp[1]  = (cls == CLS_FP) || stores_fp(kind);
  end

endmodule

// File: rtl/dig_hazard.sv
module dig_hazard #(
  parameter int REG_W = 5
) (
  input  logic              a_wr_fp,
  input  logic [REG_W-1:0]  a_wr_idx,
  input  logic [1:0]        a_rd_fp,
  input  logic [REG_W-1:0]  a_rd_idx [2],
  input  logic              b_wr_fp,
  input  logic [REG_W-1:0]  b_wr_idx,
  input  logic [1:0]        b_rd_fp,
  input  logic [REG_W-1:0]  b_rd_idx [2],
  output logic              raw_hit,
  output logic              waw_hit,
  output logic              war_hit
);

  logic [1:0] raw_v;
  logic [1:0] war_v;

  for (genvar k = 0; k < 2; k++) begin : g_src
    assign raw_v[k] = a_wr_fp && b_rd_fp[k] && (a_wr_idx == b_rd_idx[k]);
    assign war_v[k] = a_rd_fp[k] && b_wr_fp && (a_rd_idx[k] == b_wr_idx);
  end

  assign raw_hit = |raw_v;
  assign war_hit = |war_v;
  assign waw_hit = a_wr_fp && b_wr_fp && (a_wr_idx == b_wr_idx);

endmodule

// File: rtl/dig_issue_ctrl.sv
module dig_issue_ctrl
  import dig_pkg::*;
(
  input  logic      v0,
  input  logic      r0,
  input  logic      v1,
  input  logic      r1,
  input  op_class_e cls0,
  input  op_class_e cls1,
  input  logic      dep_hit,
  output logic      pair_ok,
  output logic      iss0,
  output logic      iss1,
  output logic      stall,
  output logic      shift_one
);

  logic slot0_done;

  always_comb begin
    pair_ok    = (cls0 != CLS_FP) && (cls1 == CLS_FP);
    iss0       = v0 && r0;
    iss1       = iss0 && v1 && r1 && pair_ok && !dep_hit;
    stall      = v0 && !iss0;
    slot0_done = !v0 || iss0;
    shift_one  = slot0_done && v1 && !iss1;
  end

endmodule

// File: rtl/dual_issue_gate.sv
module dual_issue_gate
  import dig_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s0_valid,
  input  logic [KIND_W-1:0] s0_kind,
  input  logic [REG_W-1:0]  s0_rd,
  input  logic [REG_W-1:0]  s0_rs,
  input  logic [REG_W-1:0]  s0_rt,
  input  logic              s0_ready,
  input  logic              s1_valid,
  input  logic [KIND_W-1:0] s1_kind,
  input  logic [REG_W-1:0]  s1_rd,
  input  logic [REG_W-1:0]  s1_rs,
  input  logic [REG_W-1:0]  s1_rt,
  input  logic              s1_ready,
  output logic              iss0_en,
  output logic              iss1_en,
  output logic              stall,
  output logic              shift_one,
  output logic              disp0_q,
  output logic              disp1_q
);

  localparam int NSLOT = 2;

  logic [KIND_W-1:0] kind_a  [NSLOT];
  logic [REG_W-1:0]  rd_a    [NSLOT];
  logic [REG_W-1:0]  rs_a    [NSLOT];
  logic [REG_W-1:0]  rt_a    [NSLOT];
  op_class_e         cls_a   [NSLOT];
  logic              wrfp_a  [NSLOT];
  logic [REG_W-1:0]  wridx_a [NSLOT];
  logic [1:0]        rdfp_a  [NSLOT];
  logic [REG_W-1:0]  rdidx0  [2];
  logic [REG_W-1:0]  rdidx1  [2];

  assign kind_a[0] = s0_kind;
  assign kind_a[1] = s1_kind;
  assign rd_a[0]   = s0_rd;
  assign rd_a[1]   = s1_rd;
  assign rs_a[0]   = s0_rs;
  assign rs_a[1]   = s1_rs;
  assign rt_a[0]   = s0_rt;
  assign rt_a[1]   = s1_rt;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [REG_W-1:0] idx_l [2];
    dig_slot_decode #(.REG_W(REG_W)) u_dec (
      .kind   (kind_a[s]),
      .rd     (rd_a[s]),
      .rs     (rs_a[s]),
      .rt     (rt_a[s]),
      .cls    (cls_a[s]),
      .wr_fp  (wrfp_a[s]),
      .wr_idx (wridx_a[s]),
      .rd_fp  (rdfp_a[s]),
      .rd_idx (idx_l)
    );
    if (s == 0) begin : g_a
      assign rdidx0 = idx_l;
    end else begin : g_b
      assign rdidx1 = idx_l;
    end
  end

  // conflict events, named for the checker
  logic raw_hit;
  logic waw_hit;
  logic war_hit;
  logic dep_hit;
  logic pair_ok;

  dig_hazard #(.REG_W(REG_W)) u_haz (
    .a_wr_fp  (wrfp_a[0]),
    .a_wr_idx (wridx_a[0]),
    .a_rd_fp  (rdfp_a[0]),
    .a_rd_idx (rdidx0),
    .b_wr_fp  (wrfp_a[1]),
    .b_wr_idx (wridx_a[1]),
    .b_rd_fp  (rdfp_a[1]),
    .b_rd_idx (rdidx1),
    .raw_hit  (raw_hit),
    .waw_hit  (waw_hit),
    .war_hit  (war_hit)
  );

  assign dep_hit = raw_hit || waw_hit || war_hit;

  dig_issue_ctrl u_ctl (
    .v0        (s0_valid),
    .r0        (s0_ready),
    .v1        (s1_valid),
    .r1        (s1_ready),
    .cls0      (cls_a[0]),
    .cls1      (cls_a[1]),
    .dep_hit   (dep_hit),
    .pair_ok   (pair_ok),
    .iss0      (iss0_en),
    .iss1      (iss1_en),
    .stall     (stall),
    .shift_one (shift_one)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disp0_q <= 1'b0;
      disp1_q <= 1'b0;
    end else begin
      disp0_q <= iss0_en;
      disp1_q <= iss1_en;
    end
  end

endmodule

// File: rtl/dual_issue_gate_chk.sv
module dual_issue_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       s0_ready,
  input logic       s1_ready,
  input logic [3:0] s0_kind,
  input logic [3:0] s1_kind,
  input logic       iss0_en,
  input logic       iss1_en,
  input logic       stall,
  input logic       shift_one,
  input logic       disp0_q,
  input logic       disp1_q,
  input logic       raw_hit,
  input logic       waw_hit,
  input logic       war_hit
);

  assert_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !s0_ready |-> !iss0_en);

  assert_in_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    iss1_en |-> iss0_en);

  assert_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
    iss1_en |-> (s1_kind[3:2] == 2'b11) && (s0_kind[3:2] != 2'b11));

  assert_raw_R4: assert property (@(posedge clk) disable iff (!rst_n)
    raw_hit |-> !iss1_en);

  assert_waw_R5: assert property (@(posedge clk) disable iff (!rst_n)
    waw_hit |-> !iss1_en);

  assert_war_R6: assert property (@(posedge clk) disable iff (!rst_n)
    war_hit |-> !iss1_en);

  assert_ready1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_ready |-> !iss1_en);

  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !iss0_en && !iss1_en);

  assert_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
    shift_one |-> !iss1_en && !stall);

  assert_disp0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    iss0_en |=> disp0_q);

  assert_nodisp0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !iss0_en |=> !disp0_q);

  assert_disp1_R10: assert property (@(posedge clk) disable iff (!rst_n)
    iss1_en |=> disp1_q);

  assert_nodisp1_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !iss1_en |=> !disp1_q);

endmodule

bind dual_issue_gate dual_issue_gate_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s0_ready  (s0_ready),
  .s1_ready  (s1_ready),
  .s0_kind   (s0_kind),
  .s1_kind   (s1_kind),
  .iss0_en   (iss0_en),
  .iss1_en   (iss1_en),
  .stall     (stall),
  .shift_one (shift_one),
  .disp0_q   (disp0_q),
  .disp1_q   (disp1_q),
  .raw_hit   (raw_hit),
  .waw_hit   (waw_hit),
  .war_hit   (war_hit)
);

// File: tb/dual_issue_gate_tb.sv
module dual_issue_gate_tb;

  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          s0_valid = 0, s0_ready = 0, s1_valid = 0, s1_ready = 0;
  logic [3:0]    s0_kind = 0, s1_kind = 0;
  logic [RW-1:0] s0_rd = 0, s0_rs = 0, s0_rt = 0, s1_rd = 0, s1_rs = 0, s1_rt = 0;
  logic          iss0_en, iss1_en, stall, shift_one, disp0_q, disp1_q;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  dual_issue_gate #(.REG_W(RW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .s0_valid(s0_valid), .s0_kind(s0_kind), .s0_rd(s0_rd), .s0_rs(s0_rs),
    .s0_rt(s0_rt), .s0_ready(s0_ready),
    .s1_valid(s1_valid), .s1_kind(s1_kind), .s1_rd(s1_rd), .s1_rs(s1_rs),
    .s1_rt(s1_rt), .s1_ready(s1_ready),
    .iss0_en(iss0_en), .iss1_en(iss1_en), .stall(stall),
    .shift_one(shift_one), .disp0_q(disp0_q), .disp1_q(disp1_q)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // bench restatement of the pairing rules
  function automatic bit m_fp_load(input logic [3:0] k);
    return k == 4'b0111;
  endfunction
  function automatic bit m_fp_store(input logic [3:0] k);
    return k == 4'b0101;
  endfunction
  function automatic bit m_is_fp(input logic [3:0] k);
    return k[3] & k[2];
  endfunction

  // which rule keeps slot 1 back; "" if it may go
  function automatic string m_block1(input bit v0, r0, v1, r1,
                                     input logic [3:0] k0, k1,
                                     input logic [RW-1:0] d0, a0, b0, d1, a1, b1);
    if (!(v0 && r0))                       return "R2";
    if (!v1 || !r1)                        return "R7";
    if (m_is_fp(k0) || !m_is_fp(k1))       return "R3";
    if (m_fp_load(k0) && (d0 == a1 || d0 == b1)) return "R4";
    if (m_fp_load(k0) && d0 == d1)         return "R5";
    if (m_fp_store(k0) && b0 == d1)        return "R6";
    return "";
  endfunction

  task automatic pair(input bit v0, input logic [3:0] k0,
                      input logic [RW-1:0] d0, a0, b0, input bit r0,
                      input bit v1, input logic [3:0] k1,
                      input logic [RW-1:0] d1, a1, b1, input bit r1);
    bit e0, e1, es, esh;
    string why;
    @(negedge clk);
    s0_valid = v0; s0_kind = k0; s0_rd = d0; s0_rs = a0; s0_rt = b0; s0_ready = r0;
    s1_valid = v1; s1_kind = k1; s1_rd = d1; s1_rs = a1; s1_rt = b1; s1_ready = r1;
    #1;
    why = m_block1(v0, r0, v1, r1, k0, k1, d0, a0, b0, d1, a1, b1);
    e0  = v0 && r0;
    e1  = (why == "");
    es  = v0 && !e0;
    esh = (!v0 || e0) && v1 && !e1;
    check("R1 iss0_en", iss0_en, e0);
    check(e1 ? "R7 iss1_en" : {why, " iss1_en"}, iss1_en, e1);
    check("R8 stall", stall, es);
    check("R9 shift_one", shift_one, esh);
    @(posedge clk);
    #1;
    check("R10 disp0_q", disp0_q, e0);
    check("R10 disp1_q", disp1_q, e1);
  endtask

  initial begin
    #(4 * 50000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset disp0_q", disp0_q, 1'b0);
    check("R10 reset disp1_q", disp1_q, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // clean pair: integer ALU with an independent FP op
    pair(1, 4'b0000, 5, 6, 7, 1,  1, 4'b1100, 3, 1, 2, 1);
    // slot 0 not ready -> stall (R1, R8)
    pair(1, 4'b0000, 5, 6, 7, 0,  1, 4'b1100, 3, 1, 2, 1);
    // FP load feeding FP op, rs match (R4)
    pair(1, 4'b0111, 3, 9, 0, 1,  1, 4'b1100, 8, 3, 2, 1);
    // FP load feeding FP op, rt match (R4)
    pair(1, 4'b0111, 3, 9, 0, 1,  1, 4'b1100, 8, 2, 3, 1);
    // integer load with same number does not block (R4)
    pair(1, 4'b0110, 3, 9, 0, 1,  1, 4'b1100, 8, 3, 3, 1);
    // WAW on FP destination (R5)
    pair(1, 4'b0111, 4, 9, 0, 1,  1, 4'b1100, 4, 1, 2, 1);
    // WAR against FP store data (R6)
    pair(1, 4'b0101, 0, 9, 6, 1,  1, 4'b1100, 6, 1, 2, 1);
    // integer store with same number does not block (R6)
    pair(1, 4'b0100, 0, 9, 6, 1,  1, 4'b1100, 6, 1, 2, 1);
    // FP op in slot 0 -> single issue (R3), plus a register match
    pair(1, 4'b1101, 2, 1, 1, 1,  1, 4'b1100, 2, 2, 2, 1);
    // integer op in slot 1 -> single issue (R3)
    pair(1, 4'b1000, 0, 1, 2, 1,  1, 4'b0011, 4, 5, 6, 1);
    // slot 1 not ready (R7)
    pair(1, 4'b0000, 5, 6, 7, 1,  1, 4'b1100, 3, 1, 2, 0);
    // empty slot 0, valid slot 1 -> shift, no stall (R9)
    pair(0, 4'b0000, 0, 0, 0, 1,  1, 4'b1100, 3, 1, 2, 1);
    // both empty
    pair(0, 4'b0000, 0, 0, 0, 1,  0, 4'b1100, 3, 1, 2, 1);
    // slot 1 invalid, slot 0 issues
    pair(1, 4'b0010, 1, 1, 1, 1,  0, 4'b1100, 1, 1, 1, 1);

    for (int i = 0; i < 600; i++) begin
      logic [3:0] k0, k1;
      k0 = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 2) == 0) k0 = 4'b0111;
      else if ($urandom_range(0, 4) == 0) k0 = 4'b0101;
      k1 = ($urandom_range(0, 3) != 0) ? {2'b11, 2'($urandom_range(0, 3))}
                                        : 4'($urandom_range(0, 15));
      pair($urandom_range(0, 7) != 0, k0,
           RW'($urandom_range(0, 3)), RW'($urandom_range(0, 3)),
           RW'($urandom_range(0, 3)), $urandom_range(0, 5) != 0,
           $urandom_range(0, 7) != 0, k1,
           RW'($urandom_range(0, 3)), RW'($urandom_range(0, 3)),
           RW'($urandom_range(0, 3)), $urandom_range(0, 5) != 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule